// File: doc/BRIEF.md
# Coprocessor Host Register Window

This block is the host-facing register window of a graphics coprocessor. The host reaches it through one byte-wide port with an address, write data, a write strobe and a read strobe. Behind that port sit three things: a small byte register file, a status byte pair that holds the run flag and the interrupt flag, and a set of valid flags for the lines of a 512-byte instruction cache. The cache data itself lives elsewhere.

Several registers do more than store a byte when the host touches them. The host starts the core by raising the run bit in the status low byte, or by writing the upper byte of the program counter. Lowering the run bit flushes the cache line flags and the cache base. Reading the status high byte hands back the pending interrupt and then clears it. When the core finishes, it pulses `core_done`, which drops the run flag and raises the interrupt. The host interrupt line is high whenever the interrupt flag is set and the core is not running.

A write to the screen base register raises a dirty mark. This tells the core that its column address tables are stale. The core clears the mark once it has rebuilt them.

Top module: `fx_host_window`

## Requirements
- R1: After reset, every byte of the window reads 0, and `go`, `start`, `ext_irq`, `scr_dirty` and all `line_valid` bits are 0.
- R2: A read returns its byte on `host_rdata` one cycle after `host_rd`. A byte written at an implemented register offset (below 0x40, other than the special offsets listed in R3 and R4) reads back unchanged. Offsets 0x40 to 0xFF and 0x300 and above ignore writes and read 0.
- R3: Writes to offsets 0x34 and 0x36 store only bits 6:0; bit 7 reads back as 0.
- R4: Writes to offset 0x3B are ignored; it always reads 0.
- R5: The run bit is bit 5 of the status low byte at offset 0x30. A write there that takes it from 0 to 1 sets `go` and gives a one-cycle `start` pulse in the next cycle. A write that leaves it at 1 gives no pulse.
- R6: A write to 0x30 that takes the run bit from 1 to 0 clears all `line_valid` bits and both cache base bytes (0x3E and 0x3F). A write of 0 while the run bit is already 0 flushes nothing.
- R7: A write to offset 0x1F stores the byte, sets `go` and pulses `start`.
- R8: A read of offset 0x31 returns the stored byte, including bit 7 (the interrupt flag), and then clears bit 7. If `core_done` arrives in the same cycle, the flag is set instead.
- R9: `ext_irq` is high exactly when the interrupt flag (0x31 bit 7) is 1 and the run bit is 0.
- R10: A write in the cache window 0x100 to 0x2FF whose address bits 3:0 are all ones sets `line_valid[addr[8:4]]`. Other addresses mark nothing. Reads in the cache window return 0.
- R11: A `core_done` pulse clears the run bit and sets the interrupt flag. If the host writes 0x30, 0x31 or 0x1F in the same cycle, the pulse is dropped and the host write alone takes effect.
- R12: A write to offset 0x38 sets `scr_dirty`, which stays set until `scr_dirty_clr`. If both happen in the same cycle, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 10 | Byte offset within the window |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Write strobe, one byte per cycle |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Read data, valid the cycle after `host_rd` |
| core_done | input | 1 | Core finished pulse |
| scr_dirty_clr | input | 1 | Core has rebuilt its screen tables |
| go | output | 1 | Run flag to the core |
| start | output | 1 | One-cycle start pulse |
| ext_irq | output | 1 | Interrupt line to the host |
| scr_dirty | output | 1 | Screen base changed |
| line_valid | output | 32 | Per-line cache valid flags |

## Verification
The plain store path is tried with a table of bytes written to ordinary, masked, read-only, unimplemented and cache offsets. This separates faithful storage from bit-7 masking, ignored writes and zero read-back. Run-bit writes are tried in all four old/new combinations, which tells a real start or flush apart from a write that repeats the current state. Line marking is tried at the first and last byte of lines at both ends of the window, at a non-final byte, and at a final byte just below the window, so that an error in the index or in the window compare shows up. The interrupt is driven by `core_done` alone, by direct host writes while running and while idle, and by `core_done` colliding with a status write and with a status read. These cases fix the priority order among the three sources.

// File: rtl/fxh_pkg.sv
// Shared constants for the coprocessor host register window.
// Assumes a byte-addressed window with the status pair, program counter
// high byte and cache base at fixed offsets that the core also decodes.
package fxh_pkg;

    localparam int OFS_PC_HI    = 'h01F;
    localparam int OFS_STAT_LO  = 'h030;
    localparam int OFS_STAT_HI  = 'h031;
    localparam int OFS_MASK_A   = 'h034;
    localparam int OFS_MASK_B   = 'h036;
    localparam int OFS_SCRN     = 'h038;
    localparam int OFS_VERSION  = 'h03B;
    localparam int OFS_CBASE_LO = 'h03E;
    localparam int OFS_CBASE_HI = 'h03F;

    localparam int RUN_BIT  = 5;
    localparam int IRQ_BIT  = 7;

    localparam int DEF_ADDR_W      = 10;
    localparam int DEF_REG_DEPTH   = 64;
    localparam int DEF_CACHE_BASE  = 'h100;
    localparam int DEF_CACHE_BYTES = 512;
    localparam int DEF_LINE_BYTES  = 16;

    // Bits of a host byte that a register keeps when written.
    function automatic logic [7:0] keep_mask(input int ofs);
        if (ofs == OFS_MASK_A || ofs == OFS_MASK_B) return 8'h7F;
        else if (ofs == OFS_VERSION)                return 8'h00;
        else                                        return 8'hFF;
    endfunction

endpackage

// File: rtl/fxh_reg_bytes.sv
// Plain byte register file of the window.
// Holds DEPTH bytes from offset 0. Applies the per-offset keep mask, clears
// the cache base bytes on a flush and reads 0 beyond its depth.
// Assumes the parent keeps status-pair writes away from it.
module fxh_reg_bytes
    import fxh_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DEPTH  = DEF_REG_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              flush,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [7:0] mem [DEPTH];
    logic       wr_hit;
    logic [7:0] wmask;

    // Decode whether the write lands inside the file and which bits it keeps.
    always_comb begin
        wr_hit = wr_en && (32'(wr_addr) < DEPTH);
        wmask  = keep_mask(32'(wr_addr));
    end

    // Byte storage with reset, flush of the cache base and masked writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else begin
            if (flush) begin
                mem[IDX_W'(OFS_CBASE_LO)] <= 8'h00;
                mem[IDX_W'(OFS_CBASE_HI)] <= 8'h00;
            end
            if (wr_hit && wmask != 8'h00)
                mem[wr_addr[IDX_W-1:0]] <= wr_data & wmask;
        end
    end

    // Read selection: stored byte inside the file, zero outside it.
    always_comb begin
        if (32'(rd_addr) < DEPTH) rd_byte = mem[rd_addr[IDX_W-1:0]];
        else                      rd_byte = 8'h00;
    end

endmodule

// File: rtl/fxh_status_ctl.sv
// Status byte pair with run and interrupt control.
// Runs the start, flush, interrupt set and interrupt clear side effects.
// Priority, lowest first: read clear, core done, host write.
// core_done is dropped when the host writes the status pair or the PC high
// byte. Assumes at most one host write per cycle.
module fxh_status_ctl
    import fxh_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic              core_done,
    output logic [7:0]        stat_lo,
    output logic [7:0]        stat_hi,
    output logic              start,
    output logic              flush_now
);
    logic       hit_lo, hit_hi, hit_pc, rd_hi, run_old;
    logic [7:0] lo_nx, hi_nx;
    logic       start_nx;

    // Address decode of the accesses that carry side effects.
    always_comb begin
        hit_lo  = wr_en && (32'(addr) == OFS_STAT_LO);
        hit_hi  = wr_en && (32'(addr) == OFS_STAT_HI);
        hit_pc  = wr_en && (32'(addr) == OFS_PC_HI);
        rd_hi   = rd_en && (32'(addr) == OFS_STAT_HI);
        run_old = stat_lo[RUN_BIT];
    end

    // Next state of the status pair, with later lines taking priority.
    always_comb begin
        lo_nx     = stat_lo;
        hi_nx     = stat_hi;
        start_nx  = 1'b0;
        flush_now = 1'b0;
        if (rd_hi) hi_nx[IRQ_BIT] = 1'b0;
        if (core_done && !hit_lo && !hit_hi && !hit_pc) begin
            lo_nx[RUN_BIT] = 1'b0;
            hi_nx[IRQ_BIT] = 1'b1;
        end
        if (hit_lo) begin
            lo_nx = wr_data;
            if (wr_data[RUN_BIT] && !run_old) start_nx  = 1'b1;
            if (!wr_data[RUN_BIT] && run_old) flush_now = 1'b1;
        end
        if (hit_hi) hi_nx = wr_data;
        if (hit_pc) begin
            lo_nx[RUN_BIT] = 1'b1;
            start_nx       = 1'b1;
        end
    end

    // Status registers and the registered start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_lo <= 8'h00;
            stat_hi <= 8'h00;
            start   <= 1'b0;
        end else begin
            stat_lo <= lo_nx;
            stat_hi <= hi_nx;
            start   <= start_nx;
        end
    end

endmodule

// File: rtl/fxh_line_flags.sv
// Valid flags for the lines of the instruction cache.
// A host write to the last byte of a line inside the cache window marks
// that line. The line number is taken straight from the address bits above
// the line offset, so it wraps modulo the line count. A flush clears all.
module fxh_line_flags
    import fxh_pkg::*;
#(
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int CACHE_BASE  = DEF_CACHE_BASE,
    parameter int CACHE_BYTES = DEF_CACHE_BYTES,
    parameter int LINE_BYTES  = DEF_LINE_BYTES,
    localparam int LINES      = CACHE_BYTES / LINE_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              flush,
    output logic [LINES-1:0]  valid
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(LINES);

    logic             in_win, mark;
    logic [IDX_W-1:0] idx;

    // Window check and line index of the current write.
    always_comb begin
        in_win = (32'(wr_addr) >= CACHE_BASE) &&
                 (32'(wr_addr) <  CACHE_BASE + CACHE_BYTES);
        mark   = wr_en && in_win && (&wr_addr[OFF_W-1:0]);
        idx    = wr_addr[OFF_W+IDX_W-1:OFF_W];
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // One flag per line: set on its last-byte write, cleared on flush.
        always_ff @(posedge clk) begin
            if (!rst_n)                             valid[g] <= 1'b0;
            else if (flush)                         valid[g] <= 1'b0;
            else if (mark && idx == IDX_W'(g))      valid[g] <= 1'b1;
        end
    end

endmodule

// File: rtl/fx_host_window.sv
// Top of the coprocessor host register window.
// Routes the host port to the byte file, the status pair and the line
// flags. Holds the screen dirty mark and the registered read data, and
// derives the host interrupt line. Assumes one host access address per
// cycle shared by read and write.
module fx_host_window
    import fxh_pkg::*;
#(
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int REG_DEPTH   = DEF_REG_DEPTH,
    parameter int CACHE_BASE  = DEF_CACHE_BASE,
    parameter int CACHE_BYTES = DEF_CACHE_BYTES,
    parameter int LINE_BYTES  = DEF_LINE_BYTES,
    localparam int LINES      = CACHE_BYTES / LINE_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [7:0]        host_rdata,
    input  logic              core_done,
    input  logic              scr_dirty_clr,
    output logic              go,
    output logic              start,
    output logic              ext_irq,
    output logic              scr_dirty,
    output logic [LINES-1:0]  line_valid
);
    logic       is_stat_lo, is_stat_hi, file_wr, flush_now;
    logic [7:0] stat_lo, stat_hi, file_byte, rd_sel;

    // Split status-pair accesses from the plain byte file.
    always_comb begin
        is_stat_lo = (32'(host_addr) == OFS_STAT_LO);
        is_stat_hi = (32'(host_addr) == OFS_STAT_HI);
        file_wr    = host_wr && !is_stat_lo && !is_stat_hi;
    end

    fxh_reg_bytes #(.ADDR_W(ADDR_W), .DEPTH(REG_DEPTH)) u_bytes (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (file_wr),
        .wr_addr (host_addr),
        .wr_data (host_wdata),
        .flush   (flush_now),
        .rd_addr (host_addr),
        .rd_byte (file_byte)
    );

    fxh_status_ctl #(.ADDR_W(ADDR_W)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_wr),
        .addr      (host_addr),
        .wr_data   (host_wdata),
        .rd_en     (host_rd),
        .core_done (core_done),
        .stat_lo   (stat_lo),
        .stat_hi   (stat_hi),
        .start     (start),
        .flush_now (flush_now)
    );

    fxh_line_flags #(
        .ADDR_W      (ADDR_W),
        .CACHE_BASE  (CACHE_BASE),
        .CACHE_BYTES (CACHE_BYTES),
        .LINE_BYTES  (LINE_BYTES)
    ) u_lines (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_wr),
        .wr_addr (host_addr),
        .flush   (flush_now),
        .valid   (line_valid)
    );

    // Read source selection between the status pair and the file.
    always_comb begin
        if (is_stat_lo)      rd_sel = stat_lo;
        else if (is_stat_hi) rd_sel = stat_hi;
        else                 rd_sel = file_byte;
    end

    // Registered read data, captured with the value before any side effect.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= 8'h00;
        else if (host_rd) host_rdata <= rd_sel;
    end

    // Screen dirty mark: set by a screen base write, cleared by the core.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       scr_dirty <= 1'b0;
        else if (host_wr && 32'(host_addr) == OFS_SCRN)   scr_dirty <= 1'b1;
        else if (scr_dirty_clr)                           scr_dirty <= 1'b0;
    end

    // Run flag out and host interrupt from the stored status bits.
    always_comb begin
        go      = stat_lo[RUN_BIT];
        ext_irq = stat_hi[IRQ_BIT] && !stat_lo[RUN_BIT];
    end

endmodule

// File: rtl/fxh_window_chk.sv
// Property checker for the host register window, bound to the top.
// Observes only the top ports.
module fxh_window_chk
    import fxh_pkg::*;
#(
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int CACHE_BASE  = DEF_CACHE_BASE,
    parameter int CACHE_BYTES = DEF_CACHE_BYTES,
    parameter int LINE_BYTES  = DEF_LINE_BYTES,
    localparam int LINES      = CACHE_BYTES / LINE_BYTES
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic [7:0]        host_wdata,
    input logic              host_wr,
    input logic              host_rd,
    input logic              core_done,
    input logic              go,
    input logic              start,
    input logic              ext_irq,
    input logic [LINES-1:0]  line_valid
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(LINES);

    logic in_win;
    // Cache window test for the current host address.
    always_comb in_win = (32'(host_addr) >= CACHE_BASE) &&
                         (32'(host_addr) <  CACHE_BASE + CACHE_BYTES);

    a_r11_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && !host_wr) |=> (!go && ext_irq));

    a_r7_pc_hi_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && 32'(host_addr) == OFS_PC_HI) |=> (go && start));

    a_r8_read_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && 32'(host_addr) == OFS_STAT_HI && !host_wr && !core_done)
        |=> !ext_irq);

    a_r6_stop_flushes_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && 32'(host_addr) == OFS_STAT_LO && !host_wdata[RUN_BIT] && go)
        |=> (line_valid == '0));

    a_r10_last_byte_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && in_win && (&host_addr[OFF_W-1:0]))
        |=> line_valid[$past(host_addr[OFF_W+IDX_W-1:OFF_W])]);

    a_r5_start_implies_run: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> go);

endmodule

bind fx_host_window fxh_window_chk #(
    .ADDR_W      (ADDR_W),
    .CACHE_BASE  (CACHE_BASE),
    .CACHE_BYTES (CACHE_BYTES),
    .LINE_BYTES  (LINE_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .core_done  (core_done),
    .go         (go),
    .start      (start),
    .ext_irq    (ext_irq),
    .line_valid (line_valid)
);

// File: tb/fx_host_window_bench.sv
module fx_host_window_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_rdata;
    logic        core_done = 1'b0;
    logic        scr_dirty_clr = 1'b0;
    logic        go, start, ext_irq, scr_dirty;
    logic [31:0] line_valid;

    int checks = 0;
    int errors = 0;
    logic [7:0] rv;

    always #10 clk = ~clk;

    fx_host_window u_fx_host_window (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_addr     (host_addr),
        .host_wdata    (host_wdata),
        .host_wr       (host_wr),
        .host_rd       (host_rd),
        .host_rdata    (host_rdata),
        .core_done     (core_done),
        .scr_dirty_clr (scr_dirty_clr),
        .go            (go),
        .start         (start),
        .ext_irq       (ext_irq),
        .scr_dirty     (scr_dirty),
        .line_valid    (line_valid)
    );

    // Table entries: {requirement number, offset, byte written, byte expected}.
    localparam int NV = 11;
    localparam logic [29:0] VEC [NV] = '{
        {4'd2,  10'h000, 8'h5A, 8'h5A},   // R2 plain byte
        {4'd2,  10'h01E, 8'hC3, 8'hC3},   // R2 PC low byte
        {4'd3,  10'h034, 8'hFF, 8'h7F},   // R3 bit 7 dropped
        {4'd3,  10'h036, 8'h80, 8'h00},   // R3 only bit 7 set
        {4'd2,  10'h035, 8'hFF, 8'hFF},   // R2 neighbour keeps bit 7
        {4'd4,  10'h03B, 8'hAA, 8'h00},   // R4 version stays 0
        {4'd2,  10'h03C, 8'h03, 8'h03},   // R2
        {4'd12, 10'h038, 8'h12, 8'h12},   // R12 screen base stored
        {4'd2,  10'h050, 8'h77, 8'h00},   // R2 unimplemented offset
        {4'd2,  10'h300, 8'h44, 8'h00},   // R2 above the window
        {4'd10, 10'h105, 8'h99, 8'h00}    // R10 cache window reads 0
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [7:0] d, input logic cd);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d; core_done = cd;
        @(negedge clk);
        host_wr = 1'b0; core_done = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic cd, output logic [7:0] v);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a; core_done = cd;
        @(negedge clk);
        host_rd = 1'b0; core_done = 1'b0;
        v = host_rdata;
    endtask

    task automatic pulse_done();
        @(negedge clk); core_done = 1'b1;
        @(negedge clk); core_done = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(10'h000, 1'b0, rv); check("R1 byte 0x000", rv, 8'h00);
        rd(10'h030, 1'b0, rv); check("R1 status lo", rv, 8'h00);
        rd(10'h031, 1'b0, rv); check("R1 status hi", rv, 8'h00);
        check("R1 outputs", {go, start, ext_irq, scr_dirty}, 4'b0000);
        check("R1 line flags", line_valid, 32'h0);

        // Table walk: R2, R3, R4
        for (int i = 0; i < NV; i++) wr(VEC[i][25:16], VEC[i][15:8], 1'b0);
        for (int i = 0; i < NV; i++) begin
            rd(VEC[i][25:16], 1'b0, rv);
            check($sformatf("R%0d table offset %h", VEC[i][29:26], VEC[i][25:16]), rv, VEC[i][7:0]);
        end

        // R12 dirty mark, clear, and write winning over clear
        check("R12 dirty set", scr_dirty, 1'b1);
        @(negedge clk); scr_dirty_clr = 1'b1;
        @(negedge clk); scr_dirty_clr = 1'b0;
        check("R12 dirty cleared", scr_dirty, 1'b0);
        @(negedge clk); scr_dirty_clr = 1'b1; host_wr = 1'b1; host_addr = 10'h038; host_wdata = 8'h01;
        @(negedge clk); scr_dirty_clr = 1'b0; host_wr = 1'b0;
        check("R12 write beats clear", scr_dirty, 1'b1);

        // R10 line marking
        wr(10'h10F, 8'h00, 1'b0);
        wr(10'h2FF, 8'h00, 1'b0);
        wr(10'h200, 8'h00, 1'b0);
        wr(10'h0FF, 8'h00, 1'b0);
        check("R10 line flags", line_valid, (32'h1 << 16) | (32'h1 << 15));

        // R5 start on rising run bit
        wr(10'h03E, 8'h40, 1'b0);
        wr(10'h03F, 8'h12, 1'b0);
        wr(10'h030, 8'h20, 1'b0);
        check("R5 run and start", {go, start}, 2'b11);
        @(negedge clk);
        check("R5 start one cycle", start, 1'b0);
        wr(10'h030, 8'h20, 1'b0);
        check("R5 no start when already running", {go, start}, 2'b10);

        // R6 flush on falling run bit
        wr(10'h030, 8'h00, 1'b0);
        check("R6 flags flushed", line_valid, 32'h0);
        check("R6 run cleared", go, 1'b0);
        rd(10'h03E, 1'b0, rv); check("R6 cache base lo", rv, 8'h00);
        rd(10'h03F, 1'b0, rv); check("R6 cache base hi", rv, 8'h00);
        wr(10'h11F, 8'h00, 1'b0);
        wr(10'h030, 8'h00, 1'b0);
        check("R6 no flush when idle", line_valid, 32'h1 << 17);

        // R7 PC high byte starts the core
        wr(10'h01F, 8'h85, 1'b0);
        check("R7 run and start", {go, start}, 2'b11);
        rd(10'h01F, 1'b0, rv); check("R7 stored", rv, 8'h85);

        // R11 core done, then R8 read and clear
        pulse_done();
        check("R11 done stops and interrupts", {go, ext_irq}, 2'b01);
        rd(10'h030, 1'b0, rv); check("R11 run bit cleared", rv, 8'h00);
        rd(10'h031, 1'b0, rv); check("R8 read returns flag", rv, 8'h80);
        check("R8 line dropped", ext_irq, 1'b0);
        rd(10'h031, 1'b0, rv); check("R8 flag cleared", rv, 8'h00);

        // R9 interrupt gated by the run bit
        wr(10'h030, 8'h20, 1'b0);
        wr(10'h031, 8'h80, 1'b0);
        check("R9 masked while running", ext_irq, 1'b0);
        wr(10'h030, 8'h00, 1'b0);
        check("R9 raised when idle", ext_irq, 1'b1);
        rd(10'h031, 1'b0, rv);
        check("R9 cleared by read", ext_irq, 1'b0);

        // R11 host write beats core done
        wr(10'h030, 8'h20, 1'b1);
        check("R11 write wins run", {go, ext_irq}, 2'b10);
        rd(10'h031, 1'b0, rv); check("R11 done dropped", rv, 8'h00);

        // R8 core done in the same cycle as the clearing read
        rd(10'h031, 1'b1, rv);
        check("R8 read sees old value", rv, 8'h00);
        check("R8 done beats read clear", {go, ext_irq}, 2'b01);
        rd(10'h031, 1'b0, rv); check("R8 flag then read", rv, 8'h80);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule